// File: doc/BRIEF.md
# Coefficient Program Memory Loader

This block keeps up to eight complete processing programs for an array processor. Each program is 160 bits wide, held as twenty byte fields. Every field lives in its own small bank of eight bytes, and the program number indexes that bank. Software loads the programs one byte at a time. It drives an 8-bit data bus together with a field address (0 to 19) and a program address (0 to 7). After loading, the programs may be run in any order and as often as needed.

While a program runs, the block reads every field of the selected program in a single cycle and decodes it for the analog side. There are eighteen sign-magnitude template weights, of which one group of nine feeds back and one group of nine drives the input. Only one of those groups is used at a time, so one shared set of nine weight outputs presents whichever group the template select picks. Each weight is split into a 7-bit magnitude for a converter and a sign-swap flag. The offset term is split the same way. The last field carries two ternary boundary values and a 4-bit truth table for a per-cell logic gate. A write aimed at the program currently running is refused, so a running program never changes under the array.

Top module: `coef_prog_mem`

## Requirements
- R1: After reset, rd_valid, wr_reject and code_err are 0, and every stored byte reads back as 0.
- R2: A strobe on wr_en stores wr_data into field wr_field of program wr_set. A weight byte holds the sign in bit 7 (1 = negative) and the magnitude in bits 6:0.
- R3: Fields 0 to 8 are the feedback taps 0 to 8, and fields 9 to 17 are the control taps 0 to 8. With tmpl_sel = 0 the feedback taps drive the outputs; with tmpl_sel = 1 the control taps drive them. Tap k appears on wgt_mag[7k+6:7k] and on wgt_neg[k].
- R4: Field 18 is the offset. ofs_mag is bits 6:0 of that byte and ofs_neg is bit 7.
- R5: Field 19 packs three values: bits 1:0 are the boundary state, bits 3:2 are the boundary input, and bits 7:4 are the truth table. The ternary codes are 00 = 0, 01 = +1 and 11 = -1, and they appear on bnd_state and bnd_input as 2-bit two's complement. The code 10 appears as 0 and raises code_err while rd_valid is high.
- R6: A write strobe with run_en high and wr_set equal to run_set is dropped, and wr_reject goes high for one cycle, one clock later. Writes to any other program are still accepted.
- R7: The decoded outputs show the program sampled from run_set at a clock edge from that edge onward, and rd_valid follows run_en with one clock of delay.
- R8: The programs are independent of one another. Selecting them in any order, or selecting one of them again, gives back the bytes last stored for it.
- R9: A write strobe with a field address above 19 changes no stored byte and raises wr_reject one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_field | input | 5 | Field address of the write |
| wr_set | input | 3 | Program address of the write |
| wr_data | input | 8 | Byte to store |
| run_en | input | 1 | A program is executing |
| run_set | input | 3 | Program being executed |
| tmpl_sel | input | 1 | 0 selects the feedback taps, 1 selects the control taps |
| rd_valid | output | 1 | Decoded outputs are stable for the sampled program |
| wgt_mag | output | 63 | Nine 7-bit tap magnitudes |
| wgt_neg | output | 9 | Sign-swap flag for each tap |
| ofs_mag | output | 7 | Offset magnitude |
| ofs_neg | output | 1 | Offset sign |
| bnd_state | output | 2 | Boundary state, -1/0/+1, two's complement |
| bnd_input | output | 2 | Boundary input, -1/0/+1, two's complement |
| truth_tbl | output | 4 | Logic gate truth table |
| code_err | output | 1 | The boundary field holds the illegal code 10 |
| wr_reject | output | 1 | The previous write strobe was dropped |

## Verification
A bank write decoded for the wrong field or program corrupts a byte that sits unseen in storage. It comes to light only when that program is next selected, one clock after the select, and it shows up as a wrong tap, a wrong offset or a wrong boundary value. For that reason the scoreboard selects every loaded program, in both template modes and in a shuffled order. Faults in the write guard show up at once, because wr_reject rises one clock after the strobe. When a refused write slips through anyway, the stored byte changes, and that is seen as a mismatch the next time the same program is selected.

// File: rtl/coef_prog_pkg.sv
package coef_prog_pkg;
  localparam int BYTE_W   = 8;
  localparam int MAG_W    = 7;
  localparam int TERN_W   = 2;
  localparam int TRUTH_W  = 4;

  // ternary boundary code -> two's complement value; the illegal code reads as zero
  function automatic logic [TERN_W-1:0] tern_value(input logic [TERN_W-1:0] code);
    return (code == 2'b10) ? 2'b00 : code;
  endfunction

  function automatic logic tern_bad(input logic [TERN_W-1:0] code);
    return code == 2'b10;
  endfunction

  function automatic logic [MAG_W-1:0] sm_mag(input logic [BYTE_W-1:0] b);
    return b[MAG_W-1:0];
  endfunction

  function automatic logic sm_neg(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction
endpackage

// File: rtl/coef_byte_bank.sv
module coef_byte_bank #(
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/coef_write_guard.sv
module coef_write_guard #(
  parameter int NUM_FIELDS = 20,
  parameter int NUM_SETS   = 8,
  localparam int FIELD_W   = $clog2(NUM_FIELDS),
  localparam int SET_W     = $clog2(NUM_SETS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_field,
  input  logic [SET_W-1:0]   wr_set,
  input  logic               run_en,
  input  logic [SET_W-1:0]   run_set,
  output logic               wr_accept,
  output logic               wr_hit_run,
  output logic               wr_field_bad,
  output logic               wr_reject
);
  always_comb begin
    wr_hit_run   = wr_en && run_en && (wr_set == run_set);
    wr_field_bad = wr_en && (int'(wr_field) >= NUM_FIELDS);
    wr_accept    = wr_en && !wr_hit_run && !wr_field_bad;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_reject <= 1'b0;
    else        wr_reject <= wr_hit_run || wr_field_bad;
  end
endmodule

// File: rtl/coef_field_decoder.sv
module coef_field_decoder
  import coef_prog_pkg::*;
#(
  parameter int TAPS       = 9,
  localparam int NUM_FIELDS = 2 * TAPS + 2,
  localparam int OFS_FIELD  = 2 * TAPS,
  localparam int PACK_FIELD = 2 * TAPS + 1
) (
  input  logic [NUM_FIELDS*BYTE_W-1:0] fields,
  input  logic                         tmpl_sel,
  input  logic                         valid,
  output logic [TAPS*MAG_W-1:0]        wgt_mag,
  output logic [TAPS-1:0]              wgt_neg,
  output logic [MAG_W-1:0]             ofs_mag,
  output logic                         ofs_neg,
  output logic [TERN_W-1:0]            bnd_state,
  output logic [TERN_W-1:0]            bnd_input,
  output logic [TRUTH_W-1:0]           truth_tbl,
  output logic                         code_err
);
  logic [BYTE_W-1:0] pack_b;
  logic [BYTE_W-1:0] ofs_b;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [BYTE_W-1:0] fb_b, ct_b, pick_b;
    always_comb begin
      fb_b   = fields[BYTE_W*k +: BYTE_W];
      ct_b   = fields[BYTE_W*(TAPS+k) +: BYTE_W];
      pick_b = tmpl_sel ? ct_b : fb_b;
      wgt_mag[MAG_W*k +: MAG_W] = sm_mag(pick_b);
      wgt_neg[k]                = sm_neg(pick_b);
    end
  end

  always_comb begin
    ofs_b     = fields[BYTE_W*OFS_FIELD +: BYTE_W];
    pack_b    = fields[BYTE_W*PACK_FIELD +: BYTE_W];
    ofs_mag   = sm_mag(ofs_b);
    ofs_neg   = sm_neg(ofs_b);
    bnd_state = tern_value(pack_b[1:0]);
    bnd_input = tern_value(pack_b[3:2]);
    truth_tbl = pack_b[7:4];
    code_err  = valid && (tern_bad(pack_b[1:0]) || tern_bad(pack_b[3:2]));
  end
endmodule

// File: rtl/coef_prog_mem.sv
module coef_prog_mem
  import coef_prog_pkg::*;
#(
  parameter int NUM_SETS  = 8,
  parameter int TAPS      = 9,
  localparam int NUM_FIELDS = 2 * TAPS + 2,
  localparam int FIELD_W    = $clog2(NUM_FIELDS),
  localparam int SET_W      = $clog2(NUM_SETS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [FIELD_W-1:0]      wr_field,
  input  logic [SET_W-1:0]        wr_set,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic                    run_en,
  input  logic [SET_W-1:0]        run_set,
  input  logic                    tmpl_sel,
  output logic                    rd_valid,
  output logic [TAPS*MAG_W-1:0]   wgt_mag,
  output logic [TAPS-1:0]         wgt_neg,
  output logic [MAG_W-1:0]        ofs_mag,
  output logic                    ofs_neg,
  output logic [TERN_W-1:0]       bnd_state,
  output logic [TERN_W-1:0]       bnd_input,
  output logic [TRUTH_W-1:0]      truth_tbl,
  output logic                    code_err,
  output logic                    wr_reject
);
  logic                           wr_accept;
  logic                           wr_hit_run;
  logic                           wr_field_bad;
  logic [NUM_FIELDS-1:0]          bank_we;
  logic [NUM_FIELDS*BYTE_W-1:0]   fields_q;

  coef_write_guard #(.NUM_FIELDS(NUM_FIELDS), .NUM_SETS(NUM_SETS)) u_guard (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_field(wr_field), .wr_set(wr_set),
    .run_en(run_en), .run_set(run_set), .wr_accept(wr_accept),
    .wr_hit_run(wr_hit_run), .wr_field_bad(wr_field_bad), .wr_reject(wr_reject)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_bank
    assign bank_we[f] = wr_accept && (int'(wr_field) == f);
    coef_byte_bank #(.DEPTH(NUM_SETS), .WIDTH(BYTE_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(bank_we[f]), .waddr(wr_set), .wdata(wr_data),
      .raddr(run_set), .rdata(fields_q[BYTE_W*f +: BYTE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= run_en;
  end

  coef_field_decoder #(.TAPS(TAPS)) u_dec (
    .fields(fields_q), .tmpl_sel(tmpl_sel), .valid(rd_valid),
    .wgt_mag(wgt_mag), .wgt_neg(wgt_neg), .ofs_mag(ofs_mag), .ofs_neg(ofs_neg),
    .bnd_state(bnd_state), .bnd_input(bnd_input), .truth_tbl(truth_tbl),
    .code_err(code_err)
  );
endmodule

// File: rtl/coef_prog_mem_chk.sv
module coef_prog_mem_chk #(
  parameter int SET_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SET_W-1:0] wr_set,
  input logic             run_en,
  input logic [SET_W-1:0] run_set,
  input logic             rd_valid,
  input logic             wr_reject,
  input logic             wr_accept,
  input logic             wr_field_bad,
  input logic             code_err,
  input logic [1:0]       bnd_state,
  input logic [1:0]       bnd_input,
  input logic [6:0]       ofs_mag,
  input logic [3:0]       truth_tbl
);
  p_reject_same_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run_en && wr_set == run_set) |=> wr_reject);

  p_accept_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wr_reject);

  p_bad_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_field_bad |=> wr_reject);

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> rd_valid);

  p_valid_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !rd_valid);

  p_err_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> rd_valid);

  p_tern_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_state != 2'b10) && (bnd_input != 2'b10));

  p_hold_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && run_en && $past(run_en) && run_set == $past(run_set))
      |=> ($stable(ofs_mag) && $stable(truth_tbl) && $stable(bnd_state)));
endmodule

bind coef_prog_mem coef_prog_mem_chk #(.SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_set(wr_set), .run_en(run_en),
  .run_set(run_set), .rd_valid(rd_valid), .wr_reject(wr_reject),
  .wr_accept(wr_accept), .wr_field_bad(wr_field_bad), .code_err(code_err),
  .bnd_state(bnd_state), .bnd_input(bnd_input), .ofs_mag(ofs_mag),
  .truth_tbl(truth_tbl)
);

// File: tb/coef_prog_mem_tb.sv
`timescale 1ns/1ps
module coef_prog_mem_tb;
  localparam int TAPS = 9;
  localparam int NF   = 20;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, run_en = 0, tmpl_sel = 0;
  logic [4:0] wr_field = 0;
  logic [2:0] wr_set = 0, run_set = 0;
  logic [7:0] wr_data = 0;
  logic rd_valid, ofs_neg, code_err, wr_reject;
  logic [62:0] wgt_mag;
  logic [8:0] wgt_neg;
  logic [6:0] ofs_mag;
  logic [1:0] bnd_state, bnd_input;
  logic [3:0] truth_tbl;

  coef_prog_mem u_dut (.*);

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [62:0] mag; logic [8:0] neg; logic [6:0] om; logic on;
    logic [1:0] bs; logic [1:0] bi; logic [3:0] tt; logic ce;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [7:0] shadow [8][NF];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [1:0] ref_tern(input logic [1:0] c);
    if (c == 2'b11) return 2'b11;       // -1
    else if (c == 2'b01) return 2'b01;  // +1
    else return 2'b00;
  endfunction

  function automatic exp_t predict(input int s, input bit ctl);
    exp_t e;
    for (int k = 0; k < TAPS; k++) begin
      logic [7:0] b;
      b = ctl ? shadow[s][TAPS+k] : shadow[s][k];
      e.mag[7*k +: 7] = b & 8'h7f;
      e.neg[k]        = b >> 7;
    end
    e.om = shadow[s][18] & 8'h7f;
    e.on = shadow[s][18] >> 7;
    e.bs = ref_tern(shadow[s][19][1:0]);
    e.bi = ref_tern(shadow[s][19][3:2]);
    e.tt = shadow[s][19] >> 4;
    e.ce = (shadow[s][19][1:0] == 2'b10) || (shadow[s][19][3:2] == 2'b10);
    return e;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: writes a byte, predicts acceptance and the reject flag
  task automatic wr(input int f, input int s, input logic [7:0] d, input string tag);
    bit rej;
    @(negedge clk);
    wr_en = 1; wr_field = f[4:0]; wr_set = s[2:0]; wr_data = d;
    rej = (f >= NF) || (run_en && run_set == s[2:0]);
    if (!rej) shadow[s][f] = d;
    @(negedge clk);
    wr_en = 0;
    check({tag, " wr_reject"}, wr_reject, rej);
  endtask

  // driver: selects a program, pushes the expected decode
  task automatic run(input int s, input bit ctl, input string tag);
    @(negedge clk);
    run_en = 1; run_set = s[2:0]; tmpl_sel = ctl;
    exp_q.push_back(predict(s, ctl));
    tag_q.push_back(tag);
  endtask

  // monitor: compares one result per cycle after the capturing edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      check({t, " rd_valid"}, rd_valid, 1'b1);
      check({t, " taps"}, {wgt_mag, wgt_neg}, {e.mag, e.neg});
      check({t, " offset R4"}, {ofs_mag, ofs_neg}, {e.om, e.on});
      check({t, " boundary R5"}, {bnd_state, bnd_input, truth_tbl, code_err},
            {e.bs, e.bi, e.tt, e.ce});
    end
  end

  function automatic logic [7:0] gen(input int s, input int f);
    return 8'((s * 37 + f * 11 + 5) ^ (f[0] ? 8'h80 : 8'h00));
  endfunction

  initial begin
    #(5 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 8; s++) for (int f = 0; f < NF; f++) shadow[s][f] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 idle outputs", {rd_valid, wr_reject, code_err}, 3'b000);
    run(4, 0, "R1 cleared program");
    @(negedge clk); run_en = 0;

    // R2: load programs 0, 3, 6, 7
    for (int f = 0; f < 19; f++) begin
      wr(f, 0, gen(0, f), "R2 load0");
      wr(f, 3, gen(3, f), "R2 load3");
    end
    wr(19, 0, 8'hAD, "R2 pack0");   // state +1, input -1, table 1010
    wr(19, 3, 8'h63, "R2 pack3");   // state -1, input 0, table 0110
    wr(19, 7, 8'hF6, "R2 pack7");   // state illegal, input +1
    wr(19, 6, 8'h08, "R2 pack6");   // input illegal
    wr(18, 7, 8'h85, "R2 ofs7");

    // R3/R8: select in mixed order, both template modes
    run(0, 0, "R3 feedback set0");
    run(0, 1, "R3 control set0");
    run(3, 1, "R3 control set3");
    run(3, 0, "R8 feedback set3");
    run(7, 0, "R5 illegal state");
    run(6, 1, "R5 illegal input");
    run(0, 0, "R8 reselect set0");
    run(5, 1, "R8 empty set5");
    @(negedge clk);
    run_en = 0;
    @(negedge clk);
    check("R7 valid drops", rd_valid, 1'b0);
    check("R5 err needs valid", code_err, 1'b0);

    // R6: writes while set3 runs
    run(3, 0, "R6 before");
    @(negedge clk);
    wr(0, 3, 8'h7F, "R6 same set");
    wr(4, 2, 8'h99, "R6 other set");
    run(3, 0, "R6 same set unchanged");
    run(2, 0, "R6 other set written");
    @(negedge clk); run_en = 0;

    // R9: out-of-range field
    wr(22, 1, 8'hFF, "R9 bad field");
    wr(31, 1, 8'h55, "R9 top field");
    run(1, 0, "R9 set1 untouched");
    run(1, 1, "R9 set1 control");
    @(negedge clk); run_en = 0;
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule